// File: doc/BRIEF.md
# Two-Wire Register Slave with Dual Addressing

This block is a slave on a two-wire serial bus. The bus has one clock line and one open-drain data line. Through the bus, a master reads and writes a small bank of 8-bit control registers. The block runs on a fast system clock and oversamples both bus lines. Each line passes through a two-flop synchroniser, and the block detects start and stop conditions and clock edges from the synchronised copies. It never drives the bus high. It only pulls the data line low through `sda_oe`, and the pad with its pull-up sits outside the block.

Device addressing is either 7-bit or 10-bit, chosen by `mode_10b`. In each mode, the `addr_sel` strap chooses one of two device addresses. In 10-bit mode the address arrives as a header byte followed by a low-address byte. A read in this mode is made with a repeated start and the header again with the read bit set.

The first data byte of a write loads a register pointer. Each later byte is stored at the pointer, and the pointer then advances. Reads stream bytes from the pointer onward until the master declines a byte. The pointer keeps its value from one transfer to the next.

Top module: `twr_slave`

## Requirements
- R1: After reset `sda_oe` is 0. A start (SDA falling while SCL is high) opens a new address phase at any point, and any partly received byte is thrown away. A stop (SDA rising while SCL is high) returns the block to idle with `sda_oe` at 0.
- R2: With `mode_10b`=0, the first byte after a start carries the address in bits 7:1 and the read flag in bit 0 (1 = read). The byte is acknowledged only if the address is 0x2A (`addr_sel`=0) or 0x2B (`addr_sel`=1). After a mismatch, the block acknowledges nothing until the next start.
- R3: With `mode_10b`=1, a write is addressed by two bytes. The first is the header {11110, a[9:8], 0} and the second is a[7:0]. The device address is 0x1A4 (`addr_sel`=0) or 0x1A5 (`addr_sel`=1). Each byte is acknowledged only if its part of the address matches, and a failed match leaves the block silent until the next start.
- R4: In 10-bit mode, a header with the read flag set is acknowledged only if a full 10-bit write address has matched since the last stop. Otherwise the block does not acknowledge it.
- R5: In a write, the first byte after the address loads the register pointer from its low 4 bits (16 registers). Each later byte is stored at the pointer, and the pointer then increments modulo 16.
- R6: The block pulls SDA low for the whole ninth clock after each acknowledged address byte and after every data byte it receives in a write.
- R7: After a read address is acknowledged, the block shifts out the register at the pointer, most significant bit first, and the pointer advances once per byte sent. If the master pulls SDA low in the ninth clock, the block sends the next byte. If the master leaves SDA high, the block releases SDA and stays quiet until the next start.
- R8: The pointer survives stop and start. A read without a pointer byte continues from where the previous access left off.
- R9: `sda_oe` changes only while the synchronised SCL is low, so the data line is held stable while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the fastest bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| mode_10b | input | 1 | 1 selects 10-bit device addressing, 0 selects 7-bit |
| addr_sel | input | 1 | Strap that picks one of the two device addresses of the active mode |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A start condition and the framing of a byte can coincide. A repeated start may arrive while the slave is part-way through shifting in a data byte. In that case the start must win: the bit count is reset, nothing is written, and the pointer does not move. The bench provokes this by writing one register and then sending three loose bits, followed by a repeated start and a read address. It judges the result by whether the address is acknowledged and by whether the byte read back is the untouched register that follows the written one. The bench also provokes a repeated start in 10-bit mode. That start keeps the address match, while a stop clears it.

// File: rtl/twr_pkg.sv
package twr_pkg;

    // Link-level state of the slave
    typedef enum logic [2:0] {
        ST_IDLE,     // not addressed, bus ignored until a start
        ST_RX,       // shifting a byte in
        ST_ACK_TX,   // slave pulls SDA low for the ninth clock
        ST_TX,       // shifting a register byte out
        ST_ACK_RX    // master's acknowledge slot after a sent byte
    } link_state_e;

    // Meaning of the next byte that will be received
    typedef enum logic [1:0] {
        BY_ADDR1,    // first address byte (7-bit address or 10-bit header)
        BY_ADDR2,    // low eight bits of a 10-bit address
        BY_PTR,      // register pointer
        BY_DATA      // register write data
    } byte_role_e;

    // Synchronised bus view plus detected events
    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    // Verdict on a completed received byte
    typedef struct packed {
        logic       ack;
        logic       go_read;
        logic       set_ptr;
        logic       wr_en;
        logic       tenbit_ok;
        logic       tenbit_clr;
        byte_role_e next_role;
    } decision_t;

    localparam logic [4:0] TENBIT_TAG = 5'b11110;
    localparam logic [3:0] BYTE_BITS  = 4'd8;

    function automatic logic tenbit_header_hit(input logic [7:0] b, input logic [9:0] dev);
        return (b[7:3] == TENBIT_TAG) && (b[2:1] == dev[9:8]);
    endfunction

endpackage

// File: rtl/twr_bus_sampler.sv
module twr_bus_sampler
    import twr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    localparam int LAST = (SYNC_STAGES < 2) ? 1 : SYNC_STAGES - 1;

    logic [LAST:0] scl_sh;
    logic [LAST:0] sda_sh;
    logic          scl_q;
    logic          sda_q;

    // Idle bus lines read high, so reset the chains high
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[LAST-1:0], scl_i};
            sda_sh <= {sda_sh[LAST-1:0], sda_i};
            scl_q  <= scl_sh[LAST];
            sda_q  <= sda_sh[LAST];
        end
    end

    always_comb begin
        evt.scl   = scl_sh[LAST];
        evt.sda   = sda_sh[LAST];
        evt.rise  = !scl_q && scl_sh[LAST];
        evt.fall  = scl_q && !scl_sh[LAST];
        // data edges count as conditions only while the clock stays high
        evt.start = scl_q && scl_sh[LAST] && sda_q && !sda_sh[LAST];
        evt.stop  = scl_q && scl_sh[LAST] && !sda_q && sda_sh[LAST];
    end

endmodule

// File: rtl/twr_byte_decode.sv
module twr_byte_decode
    import twr_pkg::*;
#(
    parameter logic [6:0] DEV7_A  = 7'h2A,
    parameter logic [6:0] DEV7_B  = 7'h2B,
    parameter logic [9:0] DEV10_A = 10'h1A4,
    parameter logic [9:0] DEV10_B = 10'h1A5
) (
    input  byte_role_e role,
    input  logic [7:0] rx_byte,
    input  logic       mode_10b,
    input  logic       addr_sel,
    input  logic       tenbit_seen,
    output decision_t  dec
);
    logic [6:0] dev7;
    logic [9:0] dev10;
    logic       hdr_hit;

    always_comb begin
        dev7    = addr_sel ? DEV7_B : DEV7_A;
        dev10   = addr_sel ? DEV10_B : DEV10_A;
        hdr_hit = tenbit_header_hit(rx_byte, dev10);

        dec           = '0;
        dec.next_role = role;

        unique case (role)
            BY_ADDR1: begin
                if (mode_10b) begin
                    if (hdr_hit && !rx_byte[0]) begin
                        // write header: second address byte follows
                        dec.ack        = 1'b1;
                        dec.tenbit_clr = 1'b1;
                        dec.next_role  = BY_ADDR2;
                    end else if (hdr_hit && tenbit_seen) begin
                        // read header only after a full match in this transfer
                        dec.ack     = 1'b1;
                        dec.go_read = 1'b1;
                    end
                end else if (rx_byte[7:1] == dev7) begin
                    dec.ack       = 1'b1;
                    dec.go_read   = rx_byte[0];
                    dec.next_role = BY_PTR;
                end
            end
            BY_ADDR2: begin
                if (mode_10b && (rx_byte == dev10[7:0])) begin
                    dec.ack       = 1'b1;
                    dec.tenbit_ok = 1'b1;
                    dec.next_role = BY_PTR;
                end
            end
            BY_PTR: begin
                dec.ack       = 1'b1;
                dec.set_ptr   = 1'b1;
                dec.next_role = BY_DATA;
            end
            BY_DATA: begin
                dec.ack       = 1'b1;
                dec.wr_en     = 1'b1;
                dec.next_role = BY_DATA;
            end
            default: dec = '0;
        endcase
    end

endmodule

// File: rtl/twr_regbank.sv
module twr_regbank #(
    parameter int REG_COUNT = 16,
    parameter int PTR_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [7:0]       rdata
);
    logic [7:0] mem [REG_COUNT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_COUNT; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R5: a written byte is found at its address one cycle later
    assert_write_lands_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/twr_slave.sv
module twr_slave
    import twr_pkg::*;
#(
    parameter int         REG_COUNT   = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV7_A      = 7'h2A,
    parameter logic [6:0] DEV7_B      = 7'h2B,
    parameter logic [9:0] DEV10_A     = 10'h1A4,
    parameter logic [9:0] DEV10_B     = 10'h1A5
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic mode_10b,
    input  logic addr_sel,
    output logic sda_oe
);
    localparam int              PTR_W   = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
    localparam logic [PTR_W-1:0] PTR_ONE = 1;

    bus_evt_t         evt;
    decision_t        dec;
    link_state_e      state;
    byte_role_e       role;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg;
    logic [7:0]       txsh;
    logic [PTR_W-1:0] ptr;
    logic             tenbit_seen;
    logic             go_read_q;
    logic             master_ack;
    logic             wr_en;
    logic [7:0]       rd_data;
    logic             byte_done;

    twr_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) sampler_i (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    twr_byte_decode #(
        .DEV7_A (DEV7_A), .DEV7_B (DEV7_B),
        .DEV10_A(DEV10_A), .DEV10_B(DEV10_B)
    ) decode_i (
        .role        (role),
        .rx_byte     (shreg),
        .mode_10b    (mode_10b),
        .addr_sel    (addr_sel),
        .tenbit_seen (tenbit_seen),
        .dec         (dec)
    );

    twr_regbank #(.REG_COUNT(REG_COUNT), .PTR_W(PTR_W)) bank_i (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .waddr (ptr),
        .wdata (shreg),
        .raddr (ptr),
        .rdata (rd_data)
    );

    // a received byte is judged on the clock fall that ends its eighth bit
    assign byte_done = (state == ST_RX) && evt.fall && (bitcnt == BYTE_BITS)
                       && !evt.start && !evt.stop;
    assign wr_en     = byte_done && dec.ack && dec.wr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            role        <= BY_ADDR1;
            bitcnt      <= '0;
            shreg       <= '0;
            txsh        <= '0;
            ptr         <= '0;
            tenbit_seen <= 1'b0;
            go_read_q   <= 1'b0;
            master_ack  <= 1'b0;
            sda_oe      <= 1'b0;
        end else if (evt.start) begin
            // start or repeated start: drop any partial byte
            state  <= ST_RX;
            role   <= BY_ADDR1;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (evt.stop) begin
            state       <= ST_IDLE;
            role        <= BY_ADDR1;
            bitcnt      <= '0;
            sda_oe      <= 1'b0;
            tenbit_seen <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    sda_oe <= 1'b0;
                end
                ST_RX: begin
                    if (evt.rise) begin
                        shreg  <= {shreg[6:0], evt.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        if (dec.ack) begin
                            sda_oe    <= 1'b1;
                            state     <= ST_ACK_TX;
                            go_read_q <= dec.go_read;
                            role      <= dec.next_role;
                            if (dec.set_ptr)    ptr <= shreg[PTR_W-1:0];
                            if (dec.wr_en)      ptr <= ptr + PTR_ONE;
                            if (dec.tenbit_ok)  tenbit_seen <= 1'b1;
                            if (dec.tenbit_clr) tenbit_seen <= 1'b0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ACK_TX: begin
                    if (evt.fall) begin
                        bitcnt <= '0;
                        if (go_read_q) begin
                            txsh   <= rd_data;
                            ptr    <= ptr + PTR_ONE;
                            sda_oe <= !rd_data[7];
                            state  <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (evt.rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (evt.fall) begin
                        if (bitcnt == BYTE_BITS) begin
                            sda_oe <= 1'b0;
                            state  <= ST_ACK_RX;
                        end else begin
                            txsh   <= {txsh[6:0], 1'b0};
                            sda_oe <= !txsh[6];
                        end
                    end
                end
                ST_ACK_RX: begin
                    if (evt.rise) begin
                        master_ack <= !evt.sda;
                    end else if (evt.fall) begin
                        if (master_ack) begin
                            bitcnt <= '0;
                            txsh   <= rd_data;
                            ptr    <= ptr + PTR_ONE;
                            sda_oe <= !rd_data[7];
                            state  <= ST_TX;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    state  <= ST_IDLE;
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

    // R1: a stop always leaves the data line released
    assert_release_on_stop_R1: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> !sda_oe);

    // R2: an unaddressed slave never touches the bus
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    // R4: bytes go out in 10-bit mode only after a full address match
    assert_tenbit_read_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TX && mode_10b) |-> tenbit_seen);

    // R5: every stored byte advances the pointer by one
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ptr == $past(ptr) + PTR_ONE);

    // R6: an acknowledge pulse starts only after eight received bits
    assert_ack_after_byte_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_oe) && state == ST_ACK_TX) |-> $past(bitcnt) == BYTE_BITS);

    // R9: the output moves only while the synchronised clock is low
    assert_hold_while_high_R9: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe) && !$past(evt.start) && !$past(evt.stop))
            |-> !$past(evt.scl));

endmodule

// File: tb/twr_slave_tb.sv
module twr_slave_tb_top;
    localparam int Q = 16;   // system cycles per quarter bus bit

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic mode_10b = 1'b0;
    logic addr_sel = 1'b0;
    logic sda_oe;
    logic sda_line;

    int n_tests = 0;
    int n_fail  = 0;
    int r9_viol = 0;
    int hi_cnt  = 0;
    logic prev_oe = 1'b0;
    bit ended = 1'b0;
    logic [7:0] exp_mem [16];

    assign sda_line = ~(m_low | sda_oe);

    always #5 clk = ~clk;

    twr_slave dut_i (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .mode_10b (mode_10b),
        .addr_sel (addr_sel),
        .sda_oe   (sda_oe)
    );

    // R9 monitor: once SCL has settled high, the slave output must not move
    always @(negedge clk) begin
        if (scl) hi_cnt <= hi_cnt + 1; else hi_cnt <= 0;
        if (!rst && hi_cnt > 4 && sda_oe !== prev_oe) r9_viol <= r9_viol + 1;
        prev_oe <= sda_oe;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; wait_q(1);
        scl = 1'b1;   wait_q(1);
        m_low = 1'b1; wait_q(1);
        scl = 1'b0;   wait_q(1);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wait_q(1);
        scl = 1'b1;   wait_q(1);
        m_low = 1'b0; wait_q(1);
    endtask

    task automatic bit_out(input bit b);
        m_low = ~b;  wait_q(1);
        scl = 1'b1;  wait_q(2);
        scl = 1'b0;  wait_q(1);
    endtask

    task automatic bit_in(output bit b);
        m_low = 1'b0; wait_q(1);
        scl = 1'b1;   wait_q(1);
        b = sda_line; wait_q(1);
        scl = 1'b0;   wait_q(1);
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(b);
        ack = !b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit give_ack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            d[i] = b;
        end
        bit_out(!give_ack);
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        bit ack;
        bit b;
        bit exp;
        logic [7:0] d;

        for (int i = 0; i < 16; i++) exp_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(sda_oe == 1'b0, "R1 released after reset", sda_oe, 0);

        // R2 sweep of 7-bit addresses around the device, both straps
        mode_10b = 1'b0;
        for (int s = 0; s < 2; s++) begin
            for (int a = 8'h24; a <= 8'h2F; a++) begin
                addr_sel = s[0];
                bus_start();
                send_byte({a[6:0], 1'b0}, ack);
                exp = (a == 8'h2A + s);
                chk(ack == exp, "R2 7-bit address match", ack, exp);
                send_byte(8'h00, ack);
                chk(ack == exp, exp ? "R6 pointer byte ack" : "R2 silent after mismatch", ack, exp);
                bus_stop();
            end
        end

        // R5/R6: fill all registers, one extra byte wraps to register 0
        addr_sel = 1'b0;
        bus_start();
        send_byte(8'h54, ack);
        chk(ack, "R2 write address ack", ack, 1);
        send_byte(8'h00, ack);
        chk(ack, "R6 pointer ack", ack, 1);
        for (int i = 0; i <= 16; i++) begin
            send_byte(pat(i), ack);
            chk(ack, "R6 data byte ack", ack, 1);
            exp_mem[i % 16] = pat(i);
        end
        bus_stop();

        // R7: repeated-start read of five bytes from register 3
        bus_start();
        send_byte(8'h54, ack);
        send_byte(8'h03, ack);
        bus_start();
        send_byte(8'h55, ack);
        chk(ack, "R7 read address ack", ack, 1);
        for (int i = 0; i < 5; i++) begin
            recv_byte(d, i < 4);
            chk(d == exp_mem[3 + i], "R7 read data", d, exp_mem[3 + i]);
        end
        bit_in(b);
        chk(b == 1'b1, "R7 released after nack", b, 1);
        bus_stop();

        // R8: pointer carries over to a fresh transfer
        bus_start();
        send_byte(8'h55, ack);
        recv_byte(d, 1'b0);
        chk(d == exp_mem[8], "R8 pointer persists", d, exp_mem[8]);
        bus_stop();

        // R5/R7: read across the wrap point
        bus_start();
        send_byte(8'h54, ack);
        send_byte(8'h0F, ack);
        bus_start();
        send_byte(8'h55, ack);
        recv_byte(d, 1'b1);
        chk(d == exp_mem[15], "R7 read last register", d, exp_mem[15]);
        recv_byte(d, 1'b0);
        chk(d == exp_mem[0], "R5 pointer wraps", d, exp_mem[0]);
        bus_stop();

        // R1: repeated start in the middle of a data byte discards it
        bus_start();
        send_byte(8'h54, ack);
        send_byte(8'h05, ack);
        send_byte(8'h3C, ack);
        exp_mem[5] = 8'h3C;
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        bus_start();
        send_byte(8'h55, ack);
        chk(ack, "R1 address after aborted byte", ack, 1);
        recv_byte(d, 1'b0);
        chk(d == exp_mem[6], "R1 partial byte not stored", d, exp_mem[6]);
        bus_stop();

        // R3: 10-bit header sweep over address bits 9:8
        mode_10b = 1'b1;
        for (int s = 0; s < 2; s++) begin
            for (int hi = 0; hi < 4; hi++) begin
                addr_sel = s[0];
                bus_start();
                send_byte({5'b11110, hi[1:0], 1'b0}, ack);
                exp = (hi == 1);
                chk(ack == exp, "R3 header match", ack, exp);
                bus_stop();
            end
        end
        // R3: second address byte sweep
        for (int s = 0; s < 2; s++) begin
            for (int lo = 8'hA2; lo <= 8'hA7; lo++) begin
                addr_sel = s[0];
                bus_start();
                send_byte(8'hF2, ack);
                chk(ack, "R3 header ack", ack, 1);
                send_byte(lo[7:0], ack);
                exp = (lo == 8'hA4 + s);
                chk(ack == exp, "R3 low address match", ack, exp);
                bus_stop();
            end
        end
        addr_sel = 1'b0;
        bus_start();
        send_byte(8'h54, ack);
        chk(!ack, "R3 7-bit form refused in 10-bit mode", ack, 0);
        bus_stop();

        // R4: read header without a prior match
        addr_sel = 1'b1;
        bus_start();
        send_byte(8'hF3, ack);
        chk(!ack, "R4 read header without match", ack, 0);
        bus_stop();

        // 10-bit write of register 2
        bus_start();
        send_byte(8'hF2, ack);
        send_byte(8'hA5, ack);
        chk(ack, "R3 low byte ack strap 1", ack, 1);
        send_byte(8'h02, ack);
        send_byte(8'h99, ack);
        chk(ack, "R6 10-bit data ack", ack, 1);
        exp_mem[2] = 8'h99;
        bus_stop();

        // R4: repeated-start read in 10-bit mode
        bus_start();
        send_byte(8'hF2, ack);
        send_byte(8'hA5, ack);
        send_byte(8'h02, ack);
        bus_start();
        send_byte(8'hF3, ack);
        chk(ack, "R4 read header after match", ack, 1);
        recv_byte(d, 1'b1);
        chk(d == exp_mem[2], "R4 10-bit read data", d, exp_mem[2]);
        recv_byte(d, 1'b0);
        chk(d == exp_mem[3], "R7 10-bit read next", d, exp_mem[3]);
        bus_stop();

        // R4: the stop cleared the match
        bus_start();
        send_byte(8'hF3, ack);
        chk(!ack, "R4 match cleared by stop", ack, 0);
        bus_stop();

        wait_q(2);
        chk(r9_viol == 0, "R9 output stable while clock high", r9_viol, 0);
        chk(sda_oe == 1'b0, "R1 released at end", sda_oe, 0);
        finish_run();
    end

endmodule